// File: doc/BRIEF.md
# Flying-Capacitor Chopper State Controller

This block decides the gate pattern for one half of a three-level flying-capacitor chopper that keeps two series DC-link capacitors at equal voltage. On each sample strobe it compares the two link-capacitor voltages and the flying-capacitor voltage against their references using hysteresis windows. From the results it picks one of a small set of two-switch patterns. The choice of pattern lets the flying capacitor be charged or discharged while the link capacitors are being equalized.

Once a pattern is active, the block holds it until its exit condition appears on a later strobe. It then releases to a freewheel pattern with all switches off. It stays in freewheel until the inductor-current-zero flag is seen. Every change between two gate patterns passes through an all-off gap of programmable length. A final interlock never lets a forbidden switch combination reach the outputs.

Gate bit order is fixed as follows:
- `gate[0]` is the upper outer switch.
- `gate[1]` is the upper inner switch.
- `gate[2]` is the lower inner switch.
- `gate[3]` is the lower outer switch.

Top module: `fc_chopper_ctrl`

## Requirements
- R1: Each voltage is classified against its reference as above (error > +band), below (error < -band) or inside (the boundaries ±band count as inside). The link pair uses `band_link` and the flying capacitor uses `band_fly`.
- R2: When outside both-links-inside and upper-sourced, an idle strobe selects a pattern as follows. Upper-sourced means the upper link is above, or the lower link is below while the upper is not below. If the flying capacitor is not below, the pattern is 4'b0011. If the flying capacitor is below, the pattern is 4'b0101.
- R3: With both links not inside and not upper-sourced, an idle strobe selects 4'b1100.
- R4: While 4'b0101 is active in link-balancing mode, a strobe that finds the flying capacitor no longer below while the upper link is still above changes the pattern to 4'b0011.
- R5: With both links inside and the flying capacitor above, an idle strobe discharges it into the lower of the two links, provided that link voltage is below the flying voltage. A lower link gives 4'b1010 (a tie picks the lower link) and an upper link gives 4'b0101. Otherwise the block stays idle.
- R6: With both links inside and the flying capacitor below, an idle strobe charges it from the higher link, provided that link voltage exceeds the flying voltage. An upper link gives 4'b0101 (a tie picks the upper link) and a lower link gives 4'b1010.
- R7: A link-balancing pattern ends on a strobe that finds both links inside. A flying-regulation pattern ends on a strobe that finds the flying capacitor inside. Either ending leads to freewheel (all off).
- R8: Freewheel lasts until `i_zero` is high at a clock edge. A strobe arriving before or at that edge starts nothing.
- R9: Pattern decisions change only on a `sample_stb` cycle. Input changes without a strobe leave the gates unchanged.
- R10: Between two different patterns, all gates stay off for exactly `dead_cycles`+1 clock cycles.
- R11: The gate outputs never show 4'b0110, 4'b1001 or more than two bits set.
- R12: During reset, and until a strobe after it, all gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a fresh voltage sample |
| v_link_hi | input | W | Upper link-capacitor voltage sample |
| v_link_lo | input | W | Lower link-capacitor voltage sample |
| v_fly | input | W | Flying-capacitor voltage sample |
| ref_link | input | W | Link-capacitor reference |
| ref_fly | input | W | Flying-capacitor reference |
| band_link | input | W | Half-width of the link window |
| band_fly | input | W | Half-width of the flying window |
| i_zero | input | 1 | Inductor current has decayed to zero |
| dead_cycles | input | CW | All-off gap length minus one |
| gate | output | 4 | Switch gate enables |

## Verification
The selection logic is driven through a stateful walk of voltage sets that cover these cases:
- the link window boundary, one count inside and one count outside;
- each link-balancing source;
- flying-capacitor under-charge during balancing, then its recovery;
- over- and under-charge in the quiet region, with each link in turn as the lower or higher one;
- the case where no link can absorb the charge.

Freewheel is probed three ways: with demand pending and no current-zero flag, with the strobe landing on the release edge, and after release. These separate a wait for current-zero from a plain one-cycle hold. Directed runs vary the inputs without a strobe, and count the exact all-off gap between two active patterns at a dead time different from the walk's.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  // Window classification of one sampled voltage.
  typedef enum logic [1:0] {
    LVL_IN    = 2'd0,
    LVL_ABOVE = 2'd1,
    LVL_BELOW = 2'd2
  } lvl_e;

  // Switch pair selection.
  typedef enum logic [2:0] {
    P_NONE   = 3'd0,
    P_UPPER  = 3'd1,   // both upper switches
    P_LOWER  = 3'd2,   // both lower switches
    P_DIAG_A = 3'd3,   // upper outer + lower inner
    P_DIAG_B = 3'd4    // upper inner + lower outer
  } pat_e;

  // Controller operating mode.
  typedef enum logic [1:0] {
    M_IDLE     = 2'd0,
    M_ACT_LINK = 2'd1,
    M_ACT_FLY  = 2'd2,
    M_DRAIN    = 2'd3
  } mode_e;

  localparam int unsigned NGATE = 4;

  function automatic logic [NGATE-1:0] pat_bits(pat_e p);
    logic [NGATE-1:0] b;
    case (p)
      P_UPPER:  b = 4'b0011;
      P_LOWER:  b = 4'b1100;
      P_DIAG_A: b = 4'b0101;
      P_DIAG_B: b = 4'b1010;
      default:  b = 4'b0000;
    endcase
    return b;
  endfunction

  function automatic logic gates_legal(logic [NGATE-1:0] g);
    logic [2:0] ones;
    ones = 3'd0;
    for (int i = 0; i < NGATE; i++) ones = ones + {2'b00, g[i]};
    return (ones <= 3'd2) && (g != 4'b0110) && (g != 4'b1001);
  endfunction

endpackage

// File: rtl/fcc_band_cmp.sv
module fcc_band_cmp
  import fcc_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] refv,
  input  logic [W-1:0] band,
  output lvl_e         lvl
);
  localparam int unsigned EW = W + 2;

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] band_s;

  assign err    = $signed({2'b00, value}) - $signed({2'b00, refv});
  assign band_s = $signed({2'b00, band});

  always_comb begin
    if (err > band_s)       lvl = LVL_ABOVE;
    else if (err < -band_s) lvl = LVL_BELOW;
    else                    lvl = LVL_IN;
  end
endmodule

// File: rtl/fcc_state_sel.sv
module fcc_state_sel
  import fcc_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic             i_zero,
  input  lvl_e             lvl_hi,
  input  lvl_e             lvl_lo,
  input  lvl_e             lvl_fly,
  input  logic [W-1:0]     v_hi,
  input  logic [W-1:0]     v_lo,
  input  logic [W-1:0]     v_fly,
  output logic [NGATE-1:0] req_pat
);
  mode_e mode_q, mode_d;
  pat_e  code_q, code_d;

  logic region_q;    // both links inside their window
  logic up_src;
  logic fly_ok;
  pat_e fly_code;

  assign region_q = (lvl_hi == LVL_IN) && (lvl_lo == LVL_IN);
  assign up_src   = (lvl_hi == LVL_ABOVE) ||
                    ((lvl_lo == LVL_BELOW) && (lvl_hi != LVL_BELOW));

  // Quiet-region pick for the flying capacitor.
  always_comb begin
    fly_ok   = 1'b0;
    fly_code = P_NONE;
    if (lvl_fly == LVL_ABOVE) begin
      if (v_lo <= v_hi) begin
        if (v_lo < v_fly) begin fly_ok = 1'b1; fly_code = P_DIAG_B; end
      end else if (v_hi < v_fly) begin
        fly_ok = 1'b1; fly_code = P_DIAG_A;
      end
    end else if (lvl_fly == LVL_BELOW) begin
      if (v_hi >= v_lo) begin
        if (v_hi > v_fly) begin fly_ok = 1'b1; fly_code = P_DIAG_A; end
      end else if (v_lo > v_fly) begin
        fly_ok = 1'b1; fly_code = P_DIAG_B;
      end
    end
  end

  always_comb begin
    mode_d = mode_q;
    code_d = code_q;
    case (mode_q)
      M_IDLE: begin
        if (sample_stb) begin
          if (!region_q) begin
            mode_d = M_ACT_LINK;
            if (up_src) code_d = (lvl_fly == LVL_BELOW) ? P_DIAG_A : P_UPPER;
            else        code_d = P_LOWER;
          end else if (fly_ok) begin
            mode_d = M_ACT_FLY;
            code_d = fly_code;
          end
        end
      end
      M_ACT_LINK: begin
        if (sample_stb) begin
          if (region_q) begin
            mode_d = M_DRAIN;
            code_d = P_NONE;
          end else if ((code_q == P_DIAG_A) && (lvl_fly != LVL_BELOW) &&
                       (lvl_hi == LVL_ABOVE)) begin
            code_d = P_UPPER;
          end
        end
      end
      M_ACT_FLY: begin
        if (sample_stb && (lvl_fly == LVL_IN)) begin
          mode_d = M_DRAIN;
          code_d = P_NONE;
        end
      end
      M_DRAIN: begin
        if (i_zero) mode_d = M_IDLE;
      end
      default: begin
        mode_d = M_IDLE;
        code_d = P_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      code_q <= P_NONE;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

  assign req_pat = ((mode_q == M_ACT_LINK) || (mode_q == M_ACT_FLY)) ?
                   pat_bits(code_q) : '0;

  // R8
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DRAIN && !i_zero) |=> (mode_q == M_DRAIN));

  // R9
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && mode_q != M_DRAIN) |=> ($stable(mode_q) && $stable(code_q)));

endmodule

// File: rtl/fcc_gate_seq.sv
module fcc_gate_seq
  import fcc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGATE-1:0] req_pat,
  input  logic [CW-1:0]    dead_cycles,
  output logic [NGATE-1:0] gate_o
);
  logic [NGATE-1:0] gate_q, gate_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    if (req_pat != gate_q) begin
      if (gate_q != '0) begin
        gate_d = '0;
        cnt_d  = dead_cycles;
      end else if (cnt_q == '0) begin
        gate_d = req_pat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  // Final interlock.
  assign gate_o = gates_legal(gate_q) ? gate_q : '0;

  // Checker state for the all-off gap.
  logic [CW:0]      zrun_q;
  logic             seen_q;
  logic [NGATE-1:0] gprev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q  <= '0;
      seen_q  <= 1'b0;
      gprev_q <= '0;
    end else begin
      gprev_q <= gate_o;
      if (gate_o != '0) begin
        seen_q <= 1'b1;
        zrun_q <= '0;
      end else if (zrun_q != {(CW+1){1'b1}}) begin
        zrun_q <= zrun_q + 1'b1;
      end
    end
  end

  // R11
  legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gate_o) <= 2 && gate_o != 4'b0110 && gate_o != 4'b1001));

  // R10
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gprev_q != '0 && gate_o != '0) |-> (gate_o == gprev_q));

  // R10
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && gprev_q == '0 && gate_o != '0) |-> (zrun_q > {1'b0, dead_cycles}));

endmodule

// File: rtl/fc_chopper_ctrl.sv
module fc_chopper_ctrl
  import fcc_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic [W-1:0]  v_link_hi,
  input  logic [W-1:0]  v_link_lo,
  input  logic [W-1:0]  v_fly,
  input  logic [W-1:0]  ref_link,
  input  logic [W-1:0]  ref_fly,
  input  logic [W-1:0]  band_link,
  input  logic [W-1:0]  band_fly,
  input  logic          i_zero,
  input  logic [CW-1:0] dead_cycles,
  output logic [3:0]    gate
);
  localparam int unsigned NCMP = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  logic [W-1:0] cmp_val  [NCMP];
  logic [W-1:0] cmp_ref  [NCMP];
  logic [W-1:0] cmp_band [NCMP];
  lvl_e         cmp_lvl  [NCMP];

  assign cmp_val[0] = v_link_hi;  assign cmp_ref[0] = ref_link; assign cmp_band[0] = band_link;
  assign cmp_val[1] = v_link_lo;  assign cmp_ref[1] = ref_link; assign cmp_band[1] = band_link;
  assign cmp_val[2] = v_fly;      assign cmp_ref[2] = ref_fly;  assign cmp_band[2] = band_fly;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    fcc_band_cmp #(.W(W)) u_cmp (
      .value (cmp_val[g]),
      .refv  (cmp_ref[g]),
      .band  (cmp_band[g]),
      .lvl   (cmp_lvl[g])
    );
  end

  logic [NGATE-1:0] req_pat;

  fcc_state_sel #(.W(W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_s),
    .sample_stb (sample_stb),
    .i_zero     (i_zero),
    .lvl_hi     (cmp_lvl[0]),
    .lvl_lo     (cmp_lvl[1]),
    .lvl_fly    (cmp_lvl[2]),
    .v_hi       (v_link_hi),
    .v_lo       (v_link_lo),
    .v_fly      (v_fly),
    .req_pat    (req_pat)
  );

  fcc_gate_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s),
    .req_pat     (req_pat),
    .dead_cycles (dead_cycles),
    .gate_o      (gate)
  );

  // R12
  reset_off_chk: assert property (@(posedge clk) !rst_s |-> (gate == 4'b0000));

endmodule

// File: tb/sim_fc_chopper_ctrl.sv
module sim_fc_chopper_ctrl;
  localparam int W  = 12;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sample_stb;
  logic [W-1:0]  v_hi, v_lo, v_fl;
  logic          i_zero;
  logic [CW-1:0] dead;
  logic [3:0]    gate;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit illegal_seen = 0;

  always #10 clk = ~clk;

  fc_chopper_ctrl #(.W(W), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .v_link_hi(v_hi), .v_link_lo(v_lo), .v_fly(v_fl),
    .ref_link(12'd1000), .ref_fly(12'd1000),
    .band_link(12'd100), .band_fly(12'd10),
    .i_zero(i_zero), .dead_cycles(dead), .gate(gate)
  );

  typedef struct packed {
    logic [11:0] hi;
    logic [11:0] lo;
    logic [11:0] fl;
    logic        iz;
    logic [3:0]  exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{12'd1000, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd12}, // R12 quiet start
    '{12'd1100, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd1},  // R1 boundary inside
    '{12'd1101, 12'd1000, 12'd1000, 1'b1, 4'b0011, 4'd1},  // R1 one over
    '{12'd1000, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd1150, 12'd900,  12'd1000, 1'b1, 4'b0011, 4'd2},  // R2
    '{12'd1000, 12'd1000, 12'd1000, 1'b0, 4'b0000, 4'd7},  // R7 drain
    '{12'd1150, 12'd900,  12'd1000, 1'b0, 4'b0000, 4'd8},  // R8 held
    '{12'd1150, 12'd900,  12'd1000, 1'b1, 4'b0000, 4'd8},  // R8 release edge
    '{12'd1150, 12'd900,  12'd1000, 1'b1, 4'b0011, 4'd8},  // R8 after
    '{12'd1000, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd1150, 12'd900,  12'd950,  1'b1, 4'b0101, 4'd2},  // R2 fly low
    '{12'd1150, 12'd900,  12'd1000, 1'b1, 4'b0011, 4'd4},  // R4
    '{12'd1000, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd900,  12'd1150, 12'd1000, 1'b1, 4'b1100, 4'd3},  // R3
    '{12'd1000, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd1000, 12'd850,  12'd1000, 1'b1, 4'b0011, 4'd2},  // R2 lower below
    '{12'd1000, 12'd1000, 12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd1050, 12'd1020, 12'd1080, 1'b1, 4'b1010, 4'd5},  // R5 into lower
    '{12'd1050, 12'd1020, 12'd1005, 1'b1, 4'b0000, 4'd7},  // R7 fly inside
    '{12'd1020, 12'd1050, 12'd1080, 1'b1, 4'b0101, 4'd5},  // R5 into upper
    '{12'd1020, 12'd1050, 12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd1090, 12'd1095, 12'd1085, 1'b1, 4'b0000, 4'd5},  // R5 no sink
    '{12'd950,  12'd920,  12'd900,  1'b1, 4'b0101, 4'd6},  // R6 from upper
    '{12'd950,  12'd920,  12'd1000, 1'b1, 4'b0000, 4'd7},  // R7
    '{12'd920,  12'd950,  12'd900,  1'b1, 4'b1010, 4'd6},  // R6 from lower
    '{12'd920,  12'd950,  12'd1000, 1'b1, 4'b0000, 4'd7}   // R7
  };

  task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] hi, input logic [11:0] lo,
                       input logic [11:0] fl, input logic iz, input logic stb);
    @(negedge clk);
    v_hi = hi; v_lo = lo; v_fl = fl; i_zero = iz; sample_stb = stb;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  // Legality monitor on the outputs (R11).
  always @(negedge clk) begin
    if ($countones(gate) > 2 || gate == 4'b0110 || gate == 4'b1001) illegal_seen = 1;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_stb = 1'b0; i_zero = 1'b1; dead = 8'd3;
    v_hi = 12'd1150; v_lo = 12'd900; v_fl = 12'd1000;
    repeat (3) @(negedge clk);
    sample_stb = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 in reset", gate, 4'b0000);
    sample_stb = 1'b0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 after reset", gate, 4'b0000);
    v_hi = 12'd1000; v_lo = 12'd1000;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].hi, VEC[i].lo, VEC[i].fl, VEC[i].iz, 1'b1);
      total++;
      if (gate !== VEC[i].exp) begin
        bad++;
        $display("FAIL R%0d vec %0d actual=%b expected=%b", VEC[i].rq, i, gate, VEC[i].exp);
      end
    end

    // R9: no strobe, no decision.
    drive(12'd1150, 12'd900, 12'd1000, 1'b1, 1'b0);
    chk("R9 no strobe idle", gate, 4'b0000);
    drive(12'd1150, 12'd900, 12'd1000, 1'b1, 1'b1);
    chk("R9 strobe", gate, 4'b0011);
    drive(12'd1000, 12'd1000, 12'd1000, 1'b1, 1'b0);
    chk("R9 no strobe active", gate, 4'b0011);
    drive(12'd1000, 12'd1000, 12'd1000, 1'b1, 1'b1);
    chk("R9 exit", gate, 4'b0000);

    // R10: exact gap with dead_cycles = 5.
    dead = 8'd5;
    drive(12'd1150, 12'd900, 12'd950, 1'b1, 1'b1);
    chk("R10 start pattern", gate, 4'b0101);
    begin
      int zeros = 0;
      @(negedge clk);
      v_fl = 12'd1000; sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (gate == 4'b0000) zeros++;
        @(negedge clk);
      end
      total++;
      if (zeros != 6) begin
        bad++;
        $display("FAIL R10 gap actual=%0d expected=%0d", zeros, 6);
      end
      chk("R10 new pattern", gate, 4'b0011);
    end
    drive(12'd1000, 12'd1000, 12'd1000, 1'b1, 1'b1);
    chk("R7 final exit", gate, 4'b0000);

    total++;
    if (illegal_seen) begin
      bad++;
      $display("FAIL R11 actual=illegal expected=legal");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule